// File: doc/BRIEF.md
# Dual-Window Peripheral Protection Controller

This block stores the per-port security configuration for a set of peripheral protection controllers and drives their per-port control lines. Each controller instance holds three port masks: a non-secure attribute mask, a privileged-access mask used while a port is secure, and a privileged-access mask used while a port is non-secure. From these masks the block drives one nonsec line and one access-permission line per port. Software reaches the masks over a simple 32-bit register bus that has two 4 KB windows. One window is for secure software and the other is for non-secure software.

The controllers come in three groups: two internal APB-side instances, up to four APB-side expansion instances and up to four AHB-side expansion instances. Each group takes a 16-byte-aligned slot of word registers. The secure window writes the attribute masks and the secure-privileged masks. The non-secure window writes only the non-secure-privileged masks, and it uses the same offsets at which the secure window holds the secure-privileged masks. Two configuration fields, an ID byte area and two reserved internal-AHB slots complete the map.

A register access is one cycle with `req_i` high. A word write takes effect at that clock edge. Read data comes back one cycle later, with `rvalid_o` high.

Top module: `ppcctl_top`

## Requirements
- R1: For every port, `ap_o` equals that port's non-secure-privileged mask bit when its attribute bit is 1, and its secure-privileged mask bit when the attribute bit is 0. It follows every write to any of the three masks.
- R2: Every mask write is ANDed with a mask of the instance's port count (internal APB instances `P_INT` ports, expansion instances `P_EXP` ports). Mask bits at or above that count always read back as 0 and drive 0.
- R3: `nonsec_o` bit `k*PMAX+i` equals bit i of instance k's attribute mask. Instances are numbered internal APB first, then APB expansion, then AHB expansion.
- R4: Word offsets, with addr[3:2] selecting instance 0 to 3 of a group. Secure window attribute masks: AHB expansion at 0x60, internal APB at 0x70, APB expansion at 0x80. Secure window secure-privileged masks: AHB expansion at 0xA0, internal APB at 0xB0, APB expansion at 0xC0. A slot index at or beyond a group's instance count is undecoded.
- R5: The non-secure window writes and reads only the non-secure-privileged masks, at 0xA0, 0xB0 and 0xC0 (same grouping). Writes in the non-secure window never change an attribute mask, a secure-privileged mask or a configuration field. Writes in the secure window never change a non-secure-privileged mask.
- R6: A write takes effect only when `size_i` is 2 (word) and addr[1:0] is 0. Byte writes (size 0), halfword writes (size 1) and misaligned word writes change nothing.
- R7: A read of size 0 or 1 returns the addressed little-endian lanes of the 32-bit register value, shifted down by 8*addr[1:0] and zero-extended to 8 or 16 bits.
- R8: Slots 0x50 in the secure window and 0x90 in both windows read as 0 and ignore writes.
- R9: Offsets 0xFD0 to 0xFFC read one ID byte per word, in the order 04,00,00,00,52,B8,0B,00,0D,F0,05,B1. The fifth byte is 53 in the non-secure window. Writes there are ignored.
- R10: Reset clears all masks and both configuration fields, so all of `nonsec_o`, `ap_o`, `sec_resp_o` and `nsc_cfg_o` are 0.
- R11: In the secure window, offset 0x10 keeps only wdata bit 0 and drives it on `sec_resp_o`. Offset 0x14 keeps only bits [1:0] and drives them on `nsc_cfg_o`.
- R12: Any other offset reads as 0 and ignores writes. Read data appears on `rdata_o` with `rvalid_o` high in the cycle after the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| win_ns_i | input | 1 | 0 selects the secure window, 1 selects the non-secure window |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 12 | Byte offset within the window |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | High in the cycle after a read access |
| nonsec_o | output | N_INST*PMAX | Per-port non-secure attribute |
| ap_o | output | N_INST*PMAX | Per-port access permission |
| sec_resp_o | output | 1 | Secure-response configuration bit |
| nsc_cfg_o | output | 2 | Non-secure-callable configuration field |

## Verification
A write accepted at a rising edge changes `nonsec_o`, `ap_o`, `sec_resp_o` and `nsc_cfg_o` at that same edge. The bench therefore compares these outputs at the falling edge that follows the write cycle. Read data is registered, so it is due one cycle after the read access. The driver queues the expected word when it issues the read. The monitor takes it from the queue at the falling edge on which `rvalid_o` is high, and it counts a `rvalid_o` with no pending read, or a read left in the queue, as a failure.

// File: rtl/ppcctl_pkg.sv
package ppcctl_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_ZERO,
    K_SRESP,
    K_NSC,
    K_NS,
    K_SP,
    K_NSP,
    K_ID
  } kind_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Low n bits set.
  function automatic logic [31:0] port_mask(int n);
    if (n >= 32) return '1;
    return (32'd1 << n) - 32'd1;
  endfunction

  // Per port: non-secure ports take nsp, secure ports take sp.
  function automatic logic [31:0] ap_merge(logic [31:0] ns, logic [31:0] sp, logic [31:0] nsp);
    return (ns & nsp) | (~ns & sp);
  endfunction

  // Little-endian lane extraction for sub-word reads.
  function automatic logic [31:0] lane_pick(logic [31:0] w, logic [1:0] a, logic [1:0] sz);
    logic [31:0] s;
    s = w >> {a, 3'b000};
    case (sz)
      SZ_BYTE: return {24'h0, s[7:0]};
      SZ_HALF: return {16'h0, s[15:0]};
      default: return w;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(logic nswin, logic [3:0] k);
    case (k)
      4'd0:    return 8'h04;
      4'd4:    return nswin ? 8'h53 : 8'h52;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h0B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ppcctl_decode.sv
module ppcctl_decode
  import ppcctl_pkg::*;
#(
  parameter int N_APB_INT = 2,
  parameter int N_APB_EXP = 4,
  parameter int N_AHB_EXP = 4,
  parameter int IW        = 4
) (
  input  logic          win_ns_i,
  input  logic [11:0]   addr_i,
  output kind_e         kind_o,
  output logic [IW-1:0] inst_o,
  output logic [3:0]    id_idx_o
);

  logic [3:0] slot;
  logic [1:0] sub;
  assign slot = addr_i[7:4];
  assign sub  = addr_i[3:2];

  always_comb begin
    kind_o   = K_NONE;
    inst_o   = '0;
    id_idx_o = addr_i[5:2] - 4'd4;
    if (addr_i[11:8] == 4'hF && addr_i[7:0] >= 8'hD0) begin
      kind_o = K_ID;
    end else if (addr_i[11:8] == 4'h0) begin
      if (!win_ns_i) begin
        case (slot)
          4'h1: begin
            if (sub == 2'd0) kind_o = K_SRESP;
            else if (sub == 2'd1) kind_o = K_NSC;
          end
          4'h5, 4'h9: if (sub == 2'd0) kind_o = K_ZERO;
          4'h6, 4'hA: if (int'(sub) < N_AHB_EXP) begin
            kind_o = (slot == 4'h6) ? K_NS : K_SP;
            inst_o = IW'(N_APB_INT + N_APB_EXP + int'(sub));
          end
          4'h7, 4'hB: if (int'(sub) < N_APB_INT) begin
            kind_o = (slot == 4'h7) ? K_NS : K_SP;
            inst_o = IW'(int'(sub));
          end
          4'h8, 4'hC: if (int'(sub) < N_APB_EXP) begin
            kind_o = (slot == 4'h8) ? K_NS : K_SP;
            inst_o = IW'(N_APB_INT + int'(sub));
          end
          default: kind_o = K_NONE;
        endcase
      end else begin
        case (slot)
          4'h9: if (sub == 2'd0) kind_o = K_ZERO;
          4'hA: if (int'(sub) < N_AHB_EXP) begin
            kind_o = K_NSP;
            inst_o = IW'(N_APB_INT + N_APB_EXP + int'(sub));
          end
          4'hB: if (int'(sub) < N_APB_INT) begin
            kind_o = K_NSP;
            inst_o = IW'(int'(sub));
          end
          4'hC: if (int'(sub) < N_APB_EXP) begin
            kind_o = K_NSP;
            inst_o = IW'(N_APB_INT + int'(sub));
          end
          default: kind_o = K_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ppcctl_slice.sv
module ppcctl_slice
  import ppcctl_pkg::*;
#(
  parameter int PORTS = 16,
  parameter int PMAX  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_ns_i,
  input  logic            we_sp_i,
  input  logic            we_nsp_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     ns_o,
  output logic [31:0]     sp_o,
  output logic [31:0]     nsp_o,
  output logic [PMAX-1:0] ap_o
);

  localparam logic [31:0] KEEP = port_mask(PORTS);

  logic [31:0] wkeep, ns_d, sp_d, nsp_d;
  assign wkeep = wdata_i & KEEP;

  always_comb begin
    ns_d  = we_ns_i  ? wkeep : ns_o;
    sp_d  = we_sp_i  ? wkeep : sp_o;
    nsp_d = we_nsp_i ? wkeep : nsp_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_o  <= '0;
      sp_o  <= '0;
      nsp_o <= '0;
      ap_o  <= '0;
    end else begin
      ns_o  <= ns_d;
      sp_o  <= sp_d;
      nsp_o <= nsp_d;
      ap_o  <= PMAX'(ap_merge(ns_d, sp_d, nsp_d));
    end
  end

  // R1: the registered permission always agrees with the stored masks
  p_ap_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ap_o == PMAX'(ap_merge(ns_o, sp_o, nsp_o)));

  // R2: no stored bit above the port count
  p_mask_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ns_o | sp_o | nsp_o) & ~KEEP) == 32'h0);

  // R3: an attribute write lands on the next edge
  p_ns_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_ns_i |=> ns_o == ($past(wdata_i) & KEEP));

endmodule

// File: rtl/ppcctl_top.sv
module ppcctl_top
  import ppcctl_pkg::*;
#(
  parameter int N_APB_INT = 2,
  parameter int N_APB_EXP = 4,
  parameter int N_AHB_EXP = 4,
  parameter int P_INT     = 4,
  parameter int P_EXP     = 16,
  localparam int N_INST   = N_APB_INT + N_APB_EXP + N_AHB_EXP,
  localparam int PMAX     = (P_INT > P_EXP) ? P_INT : P_EXP,
  localparam int NOUT     = N_INST * PMAX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            win_ns_i,
  input  logic            we_i,
  input  logic [11:0]     addr_i,
  input  logic [1:0]      size_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            rvalid_o,
  output logic [NOUT-1:0] nonsec_o,
  output logic [NOUT-1:0] ap_o,
  output logic            sec_resp_o,
  output logic [1:0]      nsc_cfg_o
);

  localparam int IW = (N_INST > 1) ? $clog2(N_INST) : 1;

  kind_e         kind;
  logic [IW-1:0] inst;
  logic [3:0]    id_idx;

  ppcctl_decode #(
    .N_APB_INT(N_APB_INT), .N_APB_EXP(N_APB_EXP), .N_AHB_EXP(N_AHB_EXP), .IW(IW)
  ) dec_i (
    .win_ns_i (win_ns_i),
    .addr_i   (addr_i),
    .kind_o   (kind),
    .inst_o   (inst),
    .id_idx_o (id_idx)
  );

  // Named access events
  logic wr_ok, rd_ok;
  assign wr_ok = req_i && we_i && (size_i == SZ_WORD) && (addr_i[1:0] == 2'b00);
  assign rd_ok = req_i && !we_i;

  logic [31:0] ns_arr  [N_INST];
  logic [31:0] sp_arr  [N_INST];
  logic [31:0] nsp_arr [N_INST];
  logic [N_INST*32-1:0] ns_all, sp_all, nsp_all;

  for (genvar k = 0; k < N_INST; k++) begin : g_inst
    localparam int PK = (k < N_APB_INT) ? P_INT : P_EXP;
    logic hit;
    assign hit = wr_ok && (inst == IW'(k));
    ppcctl_slice #(.PORTS(PK), .PMAX(PMAX)) slice_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_ns_i  (hit && kind == K_NS),
      .we_sp_i  (hit && kind == K_SP),
      .we_nsp_i (hit && kind == K_NSP),
      .wdata_i  (wdata_i),
      .ns_o     (ns_arr[k]),
      .sp_o     (sp_arr[k]),
      .nsp_o    (nsp_arr[k]),
      .ap_o     (ap_o[k*PMAX +: PMAX])
    );
    assign nonsec_o[k*PMAX +: PMAX] = ns_arr[k][PMAX-1:0];
    assign ns_all[k*32 +: 32]  = ns_arr[k];
    assign sp_all[k*32 +: 32]  = sp_arr[k];
    assign nsp_all[k*32 +: 32] = nsp_arr[k];
  end

  logic       sresp_q;
  logic [1:0] nsc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sresp_q <= 1'b0;
      nsc_q   <= 2'b00;
    end else if (wr_ok) begin
      if (kind == K_SRESP) sresp_q <= wdata_i[0];
      if (kind == K_NSC)   nsc_q   <= wdata_i[1:0];
    end
  end

  assign sec_resp_o = sresp_q;
  assign nsc_cfg_o  = nsc_q;

  logic [31:0] rword;
  always_comb begin
    case (kind)
      K_SRESP: rword = {31'h0, sresp_q};
      K_NSC:   rword = {30'h0, nsc_q};
      K_NS:    rword = ns_arr[inst];
      K_SP:    rword = sp_arr[inst];
      K_NSP:   rword = nsp_arr[inst];
      K_ID:    rword = {24'h0, id_byte(win_ns_i, id_idx)};
      default: rword = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= 32'h0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_ok;
      if (rd_ok) rdata_o <= lane_pick(rword, addr_i[1:0], size_i);
    end
  end

  // R5: secure-window writes never reach the non-secure-privileged masks
  p_win_nsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && !win_ns_i) |=> $stable(nsp_all));

  // R5: non-secure-window writes leave secure-owned state alone
  p_win_sec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && win_ns_i) |=> ($stable(ns_all) && $stable(sp_all) && $stable({sresp_q, nsc_q})));

  // R6: sub-word or misaligned writes change nothing
  p_subword_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && !wr_ok) |=> ($stable(ns_all) && $stable(sp_all) && $stable(nsp_all) && $stable({sresp_q, nsc_q})));

  // R12: undecoded writes change nothing
  p_undecoded_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && kind == K_NONE) |=> ($stable(ns_all) && $stable(sp_all) && $stable(nsp_all) && $stable({sresp_q, nsc_q})));

  // R10: state leaves reset cleared
  p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ns_all == '0 && sp_all == '0 && nsp_all == '0 && !sec_resp_o && nsc_cfg_o == 2'b00));

endmodule

// File: tb/ppcctl_top_tb_top.sv
`timescale 1ns/1ps
module ppcctl_top_tb_top;

  localparam int NI = 10;
  localparam int PM = 16;
  localparam int NO = NI * PM;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, win = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [1:0]    size = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic [NO-1:0] nonsec, ap;
  logic          sresp;
  logic [1:0]    nsc;

  always #4 clk = ~clk;

  ppcctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .win_ns_i(win), .we_i(we),
    .addr_i(addr), .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
    .rvalid_o(rvalid), .nonsec_o(nonsec), .ap_o(ap),
    .sec_resp_o(sresp), .nsc_cfg_o(nsc)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] ns_m [NI];
  logic [31:0] sp_m [NI];
  logic [31:0] nsp_m[NI];
  logic        sresp_m;
  logic [1:0]  nsc_m;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic int pc(int k);
    return (k < 2) ? 4 : 16;
  endfunction

  function automatic logic [31:0] keep(int k);
    return (32'd1 << pc(k)) - 32'd1;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < NI; k++) begin ns_m[k] = 0; sp_m[k] = 0; nsp_m[k] = 0; end
    sresp_m = 0; nsc_m = 0;
  endtask

  // Map: 0x6_/0xA_ AHB exp (inst 6..9), 0x7_/0xB_ APB int (0..1), 0x8_/0xC_ APB exp (2..5)
  function automatic int inst_of(logic [3:0] slot, int i);
    case (slot)
      4'h6, 4'hA: return (i < 4) ? 6 + i : -1;
      4'h7, 4'hB: return (i < 2) ? i : -1;
      4'h8, 4'hC: return (i < 4) ? 2 + i : -1;
      default:    return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(bit w, logic [11:0] a);
    logic [11:0] o;
    int i, k;
    o = {a[11:2], 2'b00};
    i = int'(o[3:2]);
    if (o >= 12'hFD0) begin
      case (int'((o - 12'hFD0) >> 2))
        0: return 32'h04;  4: return w ? 32'h53 : 32'h52;
        5: return 32'hB8;  6: return 32'h0B;  8: return 32'h0D;
        9: return 32'hF0; 10: return 32'h05; 11: return 32'hB1;
        default: return 0;
      endcase
    end
    if (o[11:8] != 0) return 0;
    k = inst_of(o[7:4], i);
    if (!w) begin
      if (o == 12'h010) return {31'h0, sresp_m};
      if (o == 12'h014) return {30'h0, nsc_m};
      if (k < 0) return 0;
      if (o[7:4] inside {4'h6, 4'h7, 4'h8}) return ns_m[k];
      if (o[7:4] inside {4'hA, 4'hB, 4'hC}) return sp_m[k];
      return 0;
    end
    if (k >= 0 && o[7:4] inside {4'hA, 4'hB, 4'hC}) return nsp_m[k];
    return 0;
  endfunction

  function automatic logic [31:0] sub_word(logic [31:0] v, logic [1:0] a, logic [1:0] sz);
    logic [31:0] t;
    t = v;
    for (int b = 0; b < int'(a); b++) t = {8'h00, t[31:8]};
    if (sz == 0) return t & 32'hFF;
    if (sz == 1) return t & 32'hFFFF;
    return v;
  endfunction

  task automatic model_write(bit w, logic [11:0] a, logic [31:0] d);
    int k;
    k = inst_of(a[7:4], int'(a[3:2]));
    if (a[11:8] != 0) return;
    if (!w) begin
      if (a == 12'h010) sresp_m = d[0];
      else if (a == 12'h014) nsc_m = d[1:0];
      else if (k >= 0 && a[7:4] inside {4'h6, 4'h7, 4'h8}) ns_m[k] = d & keep(k);
      else if (k >= 0 && a[7:4] inside {4'hA, 4'hB, 4'hC}) sp_m[k] = d & keep(k);
    end else if (k >= 0 && a[7:4] inside {4'hA, 4'hB, 4'hC}) nsp_m[k] = d & keep(k);
  endtask

  task automatic wr(bit w, logic [11:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    req = 1; win = w; we = 1; addr = a; size = sz; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    if (sz == 2 && a[1:0] == 0) model_write(w, a, d);
  endtask

  task automatic rd(bit w, logic [11:0] a, logic [1:0] sz, string r);
    @(negedge clk);
    exp_q.push_back(sub_word(exp_word(w, a), a[1:0], sz));
    tag_q.push_back(r);
    req = 1; win = w; we = 0; addr = a; size = sz;
    @(negedge clk);
    req = 0;
  endtask

  // Scoreboard monitor: read data is due the cycle after the access
  always @(negedge clk) begin
    if (rvalid && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R12 unexpected rvalid actual=%h expected=no read", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s read actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic check_outs(string r);
    logic [NO-1:0] en, ea;
    en = '0; ea = '0;
    for (int k = 0; k < NI; k++)
      for (int i = 0; i < pc(k); i++) begin
        en[k*PM + i] = ns_m[k][i];
        ea[k*PM + i] = ns_m[k][i] ? nsp_m[k][i] : sp_m[k][i];
      end
    checks++;
    if (nonsec !== en || ap !== ea || sresp !== sresp_m || nsc !== nsc_m) begin
      failures++;
      $display("FAIL %s outputs actual ns=%h ap=%h cfg=%b%b expected ns=%h ap=%h cfg=%b%b",
               r, nonsec, ap, sresp, nsc, en, ea, sresp_m, nsc_m);
    end
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    @(negedge clk);
    check_outs("R10");
    rd(0, 12'h010, 2, "R10");
    rd(0, 12'h070, 2, "R10");

    // R2 masking, R3 nonsec
    wr(0, 12'h070, 2, 32'hFFFF_FFFF);
    check_outs("R3");
    rd(0, 12'h070, 2, "R2");
    wr(0, 12'h0B4, 2, 32'hFFFF_FFFA);
    rd(0, 12'h0B4, 2, "R2");

    // R4 AHB expansion instance 3, R1 selection
    wr(0, 12'h06C, 2, 32'h0000_8001);
    wr(0, 12'h0AC, 2, 32'hFFFF_0F0F);
    wr(1, 12'h0AC, 2, 32'h1234_F0F0);
    check_outs("R1");
    rd(0, 12'h06C, 2, "R4");
    rd(0, 12'h0AC, 2, "R4");
    rd(1, 12'h0AC, 2, "R5");
    rd(1, 12'h06C, 2, "R12");
    wr(1, 12'h0B0, 2, 32'h0000_0003);
    wr(0, 12'h0B0, 2, 32'h0000_000C);
    check_outs("R1");

    // R5 window separation
    wr(1, 12'h088, 2, 32'h0000_FFFF);
    rd(0, 12'h088, 2, "R5");
    wr(0, 12'h0C8, 2, 32'h0000_AAAA);
    rd(1, 12'h0C8, 2, "R5");
    wr(1, 12'h0C8, 2, 32'h0000_5555);
    rd(0, 12'h0C8, 2, "R5");
    wr(0, 12'h088, 2, 32'h0000_00FF);
    wr(1, 12'h010, 2, 32'h1);
    check_outs("R5");

    // R6 dropped writes
    wr(0, 12'h074, 0, 32'h0000_000F);
    wr(0, 12'h074, 1, 32'h0000_000F);
    wr(0, 12'h076, 2, 32'h0000_000F);
    rd(0, 12'h074, 2, "R6");
    check_outs("R6");

    // R7 sub-word reads
    wr(0, 12'h084, 2, 32'h0000_C3FF);
    rd(0, 12'h084, 0, "R7");
    rd(0, 12'h085, 0, "R7");
    rd(0, 12'h086, 0, "R7");
    rd(0, 12'h084, 1, "R7");
    rd(0, 12'h086, 1, "R7");
    rd(0, 12'h0FE0 - 12'h000, 0, "R7");

    // R8 reserved internal AHB slots
    wr(0, 12'h050, 2, 32'hFFFF_FFFF);
    wr(0, 12'h090, 2, 32'hFFFF_FFFF);
    wr(1, 12'h090, 2, 32'hFFFF_FFFF);
    rd(0, 12'h050, 2, "R8");
    rd(0, 12'h090, 2, "R8");
    rd(1, 12'h090, 2, "R8");
    check_outs("R8");

    // R9 ID area
    wr(0, 12'hFE0, 2, 32'hFFFF_FFFF);
    for (int j = 0; j < 12; j++) begin
      rd(0, 12'hFD0 + 12'(4 * j), 2, "R9");
      rd(1, 12'hFD0 + 12'(4 * j), 2, "R9");
    end

    // R11 configuration fields
    wr(0, 12'h010, 2, 32'hFFFF_FFFF);
    wr(0, 12'h014, 2, 32'hFFFF_FFFF);
    check_outs("R11");
    rd(0, 12'h010, 2, "R11");
    rd(0, 12'h014, 2, "R11");
    wr(0, 12'h014, 2, 32'h0000_0002);
    check_outs("R11");

    // R12 undecoded offsets
    wr(0, 12'h200, 2, 32'hFFFF_FFFF);
    wr(0, 12'h07C, 2, 32'hFFFF_FFFF);
    wr(0, 12'h018, 2, 32'hFFFF_FFFF);
    rd(0, 12'h200, 2, "R12");
    rd(0, 12'h07C, 2, "R12");
    rd(0, 12'h018, 2, "R12");
    check_outs("R12");

    // R10 reset during operation
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_clear();
    @(negedge clk);
    check_outs("R10");
    rd(0, 12'h0AC, 2, "R10");
    rd(1, 12'h0C8, 2, "R10");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R12 pending reads actual=%0d expected=0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule